// File: doc/BRIEF.md
# Prescaled Down-Counting Interval Timer

A single-channel 16-bit timer peripheral behind a plain register bus made up of an address, a write strobe, write data and registered read data. Software sets a start value, chooses whether the count wraps freely or reloads, and picks how many input clocks make up one count step. The counter steps down once per prescaled tick. Each time it arrives at zero, it latches an interrupt flag that stays set until software clears it.

The block is used as the time base of a simple system. Software can poll the live count to measure elapsed time, or it can take the interrupt as a periodic heartbeat. Register words sit on 4-byte boundaries. Address bits [3:2] pick the word: 0 is the start value, 1 is the live count, 2 is the control word, and 3 is the interrupt clear. Control word bits: 7 is run, 6 is periodic (1) or free-running (0), 5 is interrupt enable, and 3:2 is the step divider (00 divides by 1, 01 by 16, 10 by 256, 11 also by 256).

Top module: `tick_timer`

## Requirements
- R1: After synchronous reset the start value and the live count both read 0x0000FFFF, the control word reads 0 and `irq` is low.
- R2: Read data appears on `bus_rdata` one clock after the address is presented. Bits 31:16 of the start value and of the count read as zero. The control word reads back only bits 7, 6, 5, 3 and 2; all its other bits read as zero.
- R3: A write to word 0 stores the low 16 bits as the start value, copies them into the live count on the same edge and restarts the divider from zero.
- R4: While control bit 7 is clear, the count holds its value and the divider does not advance.
- R5: Divider code 00 steps the count on every clock. Code 01 steps it on every 16th clock after a start-value write, code 10 on every 256th, and code 11 behaves as code 10.
- R6: In free-running mode (bit 6 = 0) a step taken at 0x0000 gives 0xFFFF. With start value 0 and control 0x88, the count is still 0 after 255 clocks and reads 0xFFFF after 256.
- R7: In periodic mode (bit 6 = 1) a step taken at 0x0000 reloads the stored start value.
- R8: A step from 1 to 0 sets the interrupt flag, and the flag stays set. `irq` equals the flag ANDed with control bit 5, so turning bit 5 on later still raises `irq`.
- R9: A write of any value to word 3 clears the interrupt flag.
- R10: Writes to word 1 (the live count) have no effect on the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Byte address; bits 3:2 select the register word |
| bus_wr | input | 1 | Write strobe for the current address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the previous cycle's address |
| irq | output | 1 | Interrupt: latched flag AND interrupt enable |

## Verification
A wrong divider state appears as a count that is one step early or late at an exact clock offset after a start-value write. The checks read the count on the last clock before a step and on the first clock after it, so an error of a single cycle is caught. A wrong reload or wrap choice shows up on the step that leaves zero, one clock after zero is reached. A flag that is set late, lost or cleared by mistake shows up on `irq` on the clock after the step into zero, or after the enable bit or the clear write.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [1:0] {
    SEL_LOAD  = 2'd0,
    SEL_COUNT = 2'd1,
    SEL_CTRL  = 2'd2,
    SEL_ICLR  = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    DIV_1    = 2'd0,
    DIV_16   = 2'd1,
    DIV_256  = 2'd2,
    DIV_256B = 2'd3
  } div_e;

  localparam int BIT_RUN      = 7;
  localparam int BIT_PERIODIC = 6;
  localparam int BIT_IE       = 5;
  localparam int BIT_DIV_LO   = 2;

  typedef struct packed {
    logic run;
    logic periodic;
    logic ie;
    div_e div;
  } ctrl_t;

endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale
  import tmr_pkg::*;
#(
  parameter int PRE_W = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic restart,
  input  div_e div,
  output logic tick
);
  localparam int MID_W = PRE_W / 2;

  logic [PRE_W-1:0] pre_q;

  always_ff @(posedge clk) begin
    if (rst || restart) pre_q <= '0;
    else if (run)       pre_q <= pre_q + PRE_W'(1);
  end

  always_comb begin
    case (div)
      DIV_1:   tick = run;
      DIV_16:  tick = run && (&pre_q[MID_W-1:0]);
      default: tick = run && (&pre_q);
    endcase
  end

endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             load_wr,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             periodic,
  output logic [CNT_W-1:0] count,
  output logic             hit
);
  logic at_zero;

  assign at_zero = (count == '0);
  assign hit     = tick && !load_wr && (count == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst)            count <= '1;
    else if (load_wr)   count <= load_val;
    else if (tick) begin
      if (at_zero)      count <= periodic ? reload_val : '1;
      else              count <= count - CNT_W'(1);
    end
  end

endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CNT_W-1:0]  count,
  input  logic              hit,
  output logic [CNT_W-1:0]  load_q,
  output ctrl_t             ctrl_q,
  output logic              status_q,
  output logic              load_wr,
  output logic [DATA_W-1:0] rdata
);
  reg_sel_e          sel;
  logic              clr_wr;
  logic              ctrl_wr;
  logic [DATA_W-1:0] ctrl_img;
  logic [DATA_W-1:0] rd_next;

  assign sel     = reg_sel_e'(addr[3:2]);
  assign load_wr = wr && (sel == SEL_LOAD);
  assign ctrl_wr = wr && (sel == SEL_CTRL);
  assign clr_wr  = wr && (sel == SEL_ICLR);

  always_ff @(posedge clk) begin
    if (rst) begin
      load_q <= '1;
      ctrl_q <= '0;
    end else begin
      if (load_wr) load_q <= wdata[CNT_W-1:0];
      if (ctrl_wr) begin
        ctrl_q.run      <= wdata[BIT_RUN];
        ctrl_q.periodic <= wdata[BIT_PERIODIC];
        ctrl_q.ie       <= wdata[BIT_IE];
        ctrl_q.div      <= div_e'(wdata[BIT_DIV_LO+1:BIT_DIV_LO]);
      end
    end
  end

  // a step into zero in the same cycle as a clear keeps the flag set
  always_ff @(posedge clk) begin
    if (rst)         status_q <= 1'b0;
    else if (hit)    status_q <= 1'b1;
    else if (clr_wr) status_q <= 1'b0;
  end

  always_comb begin
    ctrl_img                           = '0;
    ctrl_img[BIT_RUN]                  = ctrl_q.run;
    ctrl_img[BIT_PERIODIC]             = ctrl_q.periodic;
    ctrl_img[BIT_IE]                   = ctrl_q.ie;
    ctrl_img[BIT_DIV_LO+1:BIT_DIV_LO]  = ctrl_q.div;
    case (sel)
      SEL_LOAD:  rd_next = DATA_W'(load_q);
      SEL_COUNT: rd_next = DATA_W'(count);
      SEL_CTRL:  rd_next = ctrl_img;
      default:   rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_next;
  end

endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4,
  parameter int PRE_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  logic [CNT_W-1:0] count_w;
  logic [CNT_W-1:0] load_w;
  ctrl_t            ctrl_w;
  logic             status_w;
  logic             load_wr_w;
  logic             tick_w;
  logic             hit_w;

  tmr_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .addr     (bus_addr),
    .wr       (bus_wr),
    .wdata    (bus_wdata),
    .count    (count_w),
    .hit      (hit_w),
    .load_q   (load_w),
    .ctrl_q   (ctrl_w),
    .status_q (status_w),
    .load_wr  (load_wr_w),
    .rdata    (bus_rdata)
  );

  tmr_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk     (clk),
    .rst     (rst),
    .run     (ctrl_w.run),
    .restart (load_wr_w),
    .div     (ctrl_w.div),
    .tick    (tick_w)
  );

  tmr_count #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick_w),
    .load_wr    (load_wr_w),
    .load_val   (bus_wdata[CNT_W-1:0]),
    .reload_val (load_w),
    .periodic   (ctrl_w.periodic),
    .count      (count_w),
    .hit        (hit_w)
  );

  assign irq = status_w & ctrl_w.ie;

endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [CNT_W-1:0]  count,
  input logic [CNT_W-1:0]  load,
  input logic              run,
  input logic              periodic,
  input logic              tick,
  input logic              status
);
  logic ld_wr;
  logic clr_wr;
  assign ld_wr  = bus_wr && (bus_addr[3:2] == 2'd0);
  assign clr_wr = bus_wr && (bus_addr[3:2] == 2'd3);

  assert_load_now_R3: assert property (@(posedge clk) disable iff (rst)
    ld_wr |=> count == $past(bus_wdata[CNT_W-1:0]));

  assert_stop_holds_R4: assert property (@(posedge clk) disable iff (rst)
    (!run && !ld_wr) |=> $stable(count));

  assert_no_tick_idle_R4: assert property (@(posedge clk) disable iff (rst)
    !run |-> !tick);

  assert_step_down_R5: assert property (@(posedge clk) disable iff (rst)
    (tick && !ld_wr && count != '0) |=> count == $past(count) - CNT_W'(1));

  assert_wrap_R6: assert property (@(posedge clk) disable iff (rst)
    (tick && !ld_wr && count == '0 && !periodic) |=> count == '1);

  assert_reload_R7: assert property (@(posedge clk) disable iff (rst)
    (tick && !ld_wr && count == '0 && periodic) |=> count == $past(load));

  assert_flag_sets_R8: assert property (@(posedge clk) disable iff (rst)
    (tick && !ld_wr && count == CNT_W'(1)) |=> status);

  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (status && !clr_wr) |=> status);

endmodule

bind tick_timer tmr_checker #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_wdata (bus_wdata),
  .count     (count_w),
  .load      (load_w),
  .run       (ctrl_w.run),
  .periodic  (ctrl_w.periodic),
  .tick      (tick_w),
  .status    (status_w)
);

// File: tb/test_tick_timer.sv
`timescale 1ns/1ps
module test_tick_timer;
  localparam logic [3:0] A_LOAD = 4'h0;
  localparam logic [3:0] A_CNT  = 4'h4;
  localparam logic [3:0] A_CTRL = 4'h8;
  localparam logic [3:0] A_CLR  = 4'hC;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;
  int          checks = 0;
  int          errors = 0;

  always #10 clk = ~clk;

  tick_timer i_tick_timer (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ends on the negedge after the write edge
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  // called on a negedge; captures the value held after the previous edge
  task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
    bus_addr = a;
    @(negedge clk);
    check(tag, bus_rdata, exp);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    rd(A_LOAD, 32'h0000FFFF, "R1 load after reset");
    rd(A_CNT,  32'h0000FFFF, "R1 count after reset");
    rd(A_CTRL, 32'h0,        "R1 ctrl after reset");
    check("R1 irq after reset", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_readback;
    wr(A_LOAD, 32'hABCD1234);
    rd(A_CNT,  32'h00001234, "R3 count loaded at once");
    rd(A_LOAD, 32'h00001234, "R2 load upper bits zero");
    wr(A_CTRL, 32'hFFFFFFFF);
    rd(A_CTRL, 32'h000000EC, "R2 ctrl defined bits only");
    wr(A_CTRL, 32'h0);
  endtask

  task automatic t_hold;
    wr(A_LOAD, 32'h50);
    idle(20);
    rd(A_CNT, 32'h50, "R4 stopped count holds");
    wr(A_CNT, 32'h1234);
    rd(A_CNT, 32'h50, "R10 count write ignored");
  endtask

  task automatic t_dividers;
    wr(A_CTRL, 32'h80);
    wr(A_LOAD, 32'h100);
    idle(3);
    rd(A_CNT, 32'hFD, "R5 div1 three steps");
    wr(A_CTRL, 32'h84);
    wr(A_LOAD, 32'h100);
    idle(15);
    rd(A_CNT, 32'h100, "R5 div16 before step");
    wr(A_LOAD, 32'h100);
    idle(16);
    rd(A_CNT, 32'hFF, "R5 div16 first step");
    wr(A_CTRL, 32'h8C);
    wr(A_LOAD, 32'h10);
    idle(255);
    rd(A_CNT, 32'h10, "R5 code11 before step");
    wr(A_LOAD, 32'h10);
    idle(256);
    rd(A_CNT, 32'h0F, "R5 code11 divides by 256");
  endtask

  task automatic t_free;
    wr(A_CTRL, 32'h88);
    wr(A_LOAD, 32'h0);
    idle(255);
    rd(A_CNT, 32'h0, "R6 zero held for 255 clocks");
    wr(A_LOAD, 32'h0);
    idle(256);
    rd(A_CNT, 32'hFFFF, "R6 wrap after 256 clocks");
    wr(A_CTRL, 32'h80);
    wr(A_LOAD, 32'h2);
    idle(3);
    rd(A_CNT, 32'hFFFF, "R6 div1 wrap");
  endtask

  task automatic t_periodic;
    wr(A_CTRL, 32'hC0);
    wr(A_LOAD, 32'h3);
    idle(4);
    rd(A_CNT, 32'h3, "R7 reload on step after zero");
    wr(A_LOAD, 32'h3);
    idle(5);
    rd(A_CNT, 32'h2, "R7 counts down after reload");
  endtask

  task automatic t_irq;
    wr(A_CTRL, 32'h0);
    wr(A_CLR, 32'h0);
    check("R9 irq low after clear", {31'b0, irq}, 32'h0);
    wr(A_CTRL, 32'hA0);
    wr(A_LOAD, 32'h2);
    @(negedge clk);
    check("R8 irq low at count 1", {31'b0, irq}, 32'h0);
    @(negedge clk);
    check("R8 irq on reaching zero", {31'b0, irq}, 32'h1);
    wr(A_CTRL, 32'h0);
    check("R8 irq masked by enable", {31'b0, irq}, 32'h0);
    idle(10);
    wr(A_CTRL, 32'h20);
    check("R8 flag sticky, irq on enable", {31'b0, irq}, 32'h1);
    wr(A_CLR, 32'h5A5A);
    check("R9 clear drops irq", {31'b0, irq}, 32'h0);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset;
    t_readback;
    t_hold;
    t_dividers;
    t_free;
    t_periodic;
    t_irq;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule